// File: doc/BRIEF.md
# Integer Divide and Remainder Unit

This unit computes integer quotients and remainders for a packet-filter style processor. It takes an already decoded 8-bit opcode byte, a 16-bit offset field and a destination operand. The second operand comes either from a register or from a 32-bit immediate. The opcode selects quotient or remainder and picks 32-bit or 64-bit width. The offset field picks unsigned or signed arithmetic.

A start pulse launches a sequential restoring divider that produces one quotient bit per cycle. The unit never traps. Division by zero and signed overflow give defined results. An encoding that this unit does not handle raises a one-cycle illegal flag instead of starting the divider. The result stays on the output from its completion pulse until the next completion.

Top module: `divmod_unit`

## Requirements
- R1: The opcode byte splits into an operation code in bits [7:4], a source select in bit [3] and a class in bits [2:0]. A source select of 1 takes `src_i` as the divisor. A source select of 0 takes `imm_i`, sign-extended to 64 bits.
- R2: Operation code 0x3 returns the quotient and 0x9 returns the remainder. An offset of 0 gives unsigned arithmetic and an offset of 1 gives signed arithmetic.
- R3: Class 0x7 operates on 64 bits. Class 0x4 operates on the low 32 bits of both operands and returns the result with bits [63:32] cleared.
- R4: A zero divisor yields a quotient of 0. The remainder in that case equals the dividend at the operating width.
- R5: In signed mode, dividing the most negative value of the operating width by -1 yields that most negative value as quotient and 0 as remainder.
- R6: Signed quotients truncate toward zero, and a nonzero signed remainder carries the sign of the dividend.
- R7: A start with an offset other than 0 or 1 is rejected. So is a start with any other operation code, including 0xe and 0xf, and so is a start with any other class. `illegal_o` is high for the one cycle after such a start. No done pulse follows, `busy_o` stays low and `result_o` is unchanged.
- R8: After reset, `busy_o`, `done_o`, `illegal_o` and `result_o` are all zero.
- R9: A legal start accepted in an idle cycle raises `busy_o` from the next cycle. `done_o` is high for exactly one cycle: 33 cycles after the start cycle in 32-bit mode and 65 cycles after it in 64-bit mode. `busy_o` falls in that same cycle. `result_o` takes the new value when `done_o` rises and holds it until the next completion.
- R10: `start_i` is ignored while `busy_o` is high.
- R11: A start presented in the cycle in which `done_o` is high is accepted, so operations can run back to back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Launch request, sampled while idle |
| opcode_i | input | 8 | Operation code, source select and class |
| offset_i | input | 16 | 0 selects unsigned, 1 selects signed |
| dst_i | input | 64 | Dividend |
| src_i | input | 64 | Register divisor |
| imm_i | input | 32 | Immediate divisor, sign-extended |
| busy_o | output | 1 | Division in progress |
| done_o | output | 1 | One-cycle completion pulse |
| illegal_o | output | 1 | One-cycle rejection pulse |
| result_o | output | 64 | Quotient or remainder |

## Verification
Completion of one operation and acceptance of the next can fall in the same cycle: `start_i` is driven in the very cycle `done_o` is seen high. The check is that the first result appears intact and that the second operation's busy window and completion pulse start one cycle later. The bench also provokes a start while the divider is busy, and a rejected encoding right after a completion. Every cycle it compares the busy, done and illegal flags and the result against a behavioural model that counts latency and computes results with native integer arithmetic.

// File: rtl/divmod_pkg.sv
package divmod_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_RUN, ST_FIX} state_e;

  localparam logic [3:0] OP_DIV    = 4'h3;
  localparam logic [3:0] OP_MOD    = 4'h9;
  localparam logic [2:0] CLS_NARROW = 3'h4;
  localparam logic [2:0] CLS_WIDE   = 3'h7;

  typedef struct packed {
    logic legal;
    logic is_mod;
    logic is_signed;
    logic wide;
    logic use_reg;
  } dec_t;
endpackage

// File: rtl/divmod_decode.sv
module divmod_decode
  import divmod_pkg::*;
(
  input  logic [7:0]  opcode_i,
  input  logic [15:0] offset_i,
  output dec_t        dec_o
);
  logic [3:0] op;
  logic [2:0] cls;
  logic       op_ok, cls_ok, off_ok;

  assign op  = opcode_i[7:4];
  assign cls = opcode_i[2:0];

  // 0xe/0xf are deliberately not accepted as signed variants
  assign op_ok  = (op == OP_DIV) || (op == OP_MOD);
  assign cls_ok = (cls == CLS_NARROW) || (cls == CLS_WIDE);
  assign off_ok = (offset_i[15:1] == '0);

  always_comb begin
    dec_o.legal     = op_ok && cls_ok && off_ok;
    dec_o.is_mod    = (op == OP_MOD);
    dec_o.is_signed = offset_i[0];
    dec_o.wide      = (cls == CLS_WIDE);
    dec_o.use_reg   = opcode_i[3];
  end
endmodule

// File: rtl/divmod_prep.sv
module divmod_prep
  import divmod_pkg::*;
#(
  parameter int XLEN = 64
) (
  input  dec_t              dec_i,
  input  logic [XLEN-1:0]   dst_i,
  input  logic [XLEN-1:0]   src_i,
  input  logic [XLEN/2-1:0] imm_i,
  output logic [XLEN-1:0]   dvd_mag_o,
  output logic [XLEN-1:0]   dvs_mag_o,
  output logic              neg_quo_o,
  output logic              neg_rem_o,
  output logic              dvs_zero_o
);
  localparam int HALF = XLEN / 2;

  logic [XLEN-1:0] b_raw, a_ext, b_ext;
  logic            a_neg, b_neg;

  assign b_raw = dec_i.use_reg ? src_i : {{HALF{imm_i[HALF-1]}}, imm_i};

  // widen narrow operands so one sign/magnitude path serves both widths
  always_comb begin
    if (dec_i.wide) begin
      a_ext = dst_i;
      b_ext = b_raw;
    end else if (dec_i.is_signed) begin
      a_ext = {{HALF{dst_i[HALF-1]}}, dst_i[HALF-1:0]};
      b_ext = {{HALF{b_raw[HALF-1]}}, b_raw[HALF-1:0]};
    end else begin
      a_ext = {{HALF{1'b0}}, dst_i[HALF-1:0]};
      b_ext = {{HALF{1'b0}}, b_raw[HALF-1:0]};
    end
  end

  assign a_neg      = dec_i.is_signed & a_ext[XLEN-1];
  assign b_neg      = dec_i.is_signed & b_ext[XLEN-1];
  assign dvd_mag_o  = a_neg ? (~a_ext + 1'b1) : a_ext;
  assign dvs_mag_o  = b_neg ? (~b_ext + 1'b1) : b_ext;
  assign neg_quo_o  = a_neg ^ b_neg;
  assign neg_rem_o  = a_neg;
  assign dvs_zero_o = (b_ext == '0);
endmodule

// File: rtl/divmod_core.sv
module divmod_core #(
  parameter int XLEN = 64
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            load_i,
  input  logic            wide_i,
  input  logic [XLEN-1:0] dvd_i,
  input  logic [XLEN-1:0] dvs_i,
  output logic            last_o,
  output logic [XLEN-1:0] quo_o,
  output logic [XLEN-1:0] rem_o
);
  localparam int HALF  = XLEN / 2;
  localparam int CNT_W = $clog2(XLEN + 1);

  logic [XLEN-1:0]  rem_q, dvd_q, dvs_q;
  logic [CNT_W-1:0] cnt_q;
  logic [XLEN:0]    shifted, trial;
  logic             fits;

  assign shifted = {rem_q, dvd_q[XLEN-1]};
  assign trial   = shifted - {1'b0, dvs_q};
  assign fits    = ~trial[XLEN];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rem_q <= '0;
      dvd_q <= '0;
      dvs_q <= '0;
      cnt_q <= '0;
    end else if (load_i) begin
      rem_q <= '0;
      // narrow dividend is pre-aligned so only HALF steps are needed
      dvd_q <= wide_i ? dvd_i : (dvd_i << HALF);
      dvs_q <= dvs_i;
      cnt_q <= wide_i ? CNT_W'(XLEN) : CNT_W'(HALF);
    end else if (cnt_q != '0) begin
      rem_q <= fits ? trial[XLEN-1:0] : shifted[XLEN-1:0];
      dvd_q <= {dvd_q[XLEN-2:0], fits};
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign last_o = (cnt_q == CNT_W'(1));
  assign quo_o  = dvd_q;
  assign rem_o  = rem_q;
endmodule

// File: rtl/divmod_fixup.sv
module divmod_fixup #(
  parameter int XLEN = 64
) (
  input  logic [XLEN-1:0] quo_i,
  input  logic [XLEN-1:0] rem_i,
  input  logic            is_mod_i,
  input  logic            neg_quo_i,
  input  logic            neg_rem_i,
  input  logic            dvs_zero_i,
  input  logic            wide_i,
  output logic [XLEN-1:0] res_o
);
  localparam int HALF = XLEN / 2;

  logic [XLEN-1:0] q_s, r_s, pick;

  always_comb begin
    q_s = neg_quo_i ? (~quo_i + 1'b1) : quo_i;
    if (dvs_zero_i) q_s = '0;
    r_s  = neg_rem_i ? (~rem_i + 1'b1) : rem_i;
    pick = is_mod_i ? r_s : q_s;
    res_o = wide_i ? pick : {{HALF{1'b0}}, pick[HALF-1:0]};
  end
endmodule

// File: rtl/divmod_unit.sv
module divmod_unit
  import divmod_pkg::*;
#(
  parameter int XLEN = 64
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [7:0]        opcode_i,
  input  logic [15:0]       offset_i,
  input  logic [XLEN-1:0]   dst_i,
  input  logic [XLEN-1:0]   src_i,
  input  logic [XLEN/2-1:0] imm_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              illegal_o,
  output logic [XLEN-1:0]   result_o
);
  state_e          state_q;
  dec_t            dec;
  logic            accept, core_last;
  logic [XLEN-1:0] dvd_mag, dvs_mag, quo, rem, res;
  logic            neg_quo, neg_rem, dvs_zero;
  logic            is_mod_q, wide_q, neg_quo_q, neg_rem_q, dvs_zero_q;
  logic            done_q, ill_q;
  logic [XLEN-1:0] result_q;

  divmod_decode u_dec (
    .opcode_i (opcode_i),
    .offset_i (offset_i),
    .dec_o    (dec)
  );

  divmod_prep #(.XLEN(XLEN)) u_prep (
    .dec_i      (dec),
    .dst_i      (dst_i),
    .src_i      (src_i),
    .imm_i      (imm_i),
    .dvd_mag_o  (dvd_mag),
    .dvs_mag_o  (dvs_mag),
    .neg_quo_o  (neg_quo),
    .neg_rem_o  (neg_rem),
    .dvs_zero_o (dvs_zero)
  );

  assign accept = start_i && (state_q == ST_IDLE);

  divmod_core #(.XLEN(XLEN)) u_core (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (accept && dec.legal),
    .wide_i (dec.wide),
    .dvd_i  (dvd_mag),
    .dvs_i  (dvs_mag),
    .last_o (core_last),
    .quo_o  (quo),
    .rem_o  (rem)
  );

  divmod_fixup #(.XLEN(XLEN)) u_fix (
    .quo_i      (quo),
    .rem_i      (rem),
    .is_mod_i   (is_mod_q),
    .neg_quo_i  (neg_quo_q),
    .neg_rem_i  (neg_rem_q),
    .dvs_zero_i (dvs_zero_q),
    .wide_i     (wide_q),
    .res_o      (res)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_IDLE;
      is_mod_q   <= 1'b0;
      wide_q     <= 1'b0;
      neg_quo_q  <= 1'b0;
      neg_rem_q  <= 1'b0;
      dvs_zero_q <= 1'b0;
      done_q     <= 1'b0;
      ill_q      <= 1'b0;
      result_q   <= '0;
    end else begin
      done_q <= 1'b0;
      ill_q  <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (accept && dec.legal) begin
            state_q    <= ST_RUN;
            is_mod_q   <= dec.is_mod;
            wide_q     <= dec.wide;
            neg_quo_q  <= neg_quo;
            neg_rem_q  <= neg_rem;
            dvs_zero_q <= dvs_zero;
          end else if (accept) begin
            ill_q <= 1'b1;
          end
        end
        ST_RUN: if (core_last) state_q <= ST_FIX;
        ST_FIX: begin
          result_q <= res;
          done_q   <= 1'b1;
          state_q  <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign busy_o    = (state_q != ST_IDLE);
  assign done_o    = done_q;
  assign illegal_o = ill_q;
  assign result_o  = result_q;
endmodule

// File: rtl/divmod_checker.sv
module divmod_checker #(
  parameter int XLEN = 64
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            start_i,
  input logic            busy_o,
  input logic            done_o,
  input logic            illegal_o,
  input logic [XLEN-1:0] result_o,
  input logic            wide_i
);
  AST_DONE_ENDS_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (!busy_o && $past(busy_o))); // R9
  AST_DONE_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o); // R9
  AST_BUSY_FROM_START: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> $past(start_i)); // R10
  AST_RESULT_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_o |-> $stable(result_o)); // R9
  AST_ILLEGAL_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    illegal_o |-> (!busy_o && !done_o && $past(start_i))); // R7
  AST_ILLEGAL_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    illegal_o |=> !illegal_o); // R7
  AST_NARROW_UPPER_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !wide_i) |-> (result_o[XLEN-1:XLEN/2] == '0)); // R3
endmodule

bind divmod_unit divmod_checker #(.XLEN(XLEN)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .start_i   (start_i),
  .busy_o    (busy_o),
  .done_o    (done_o),
  .illegal_o (illegal_o),
  .result_o  (result_o),
  .wide_i    (wide_q)
);

// File: tb/tb_divmod_unit.sv
module tb_divmod_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [7:0]  opc = '0;
  logic [15:0] off = '0;
  logic [63:0] dst = '0, src = '0;
  logic [31:0] imm = '0;
  logic        busy, done, ill;
  logic [63:0] res;

  int    vectors = 0, fails = 0;
  bit    finished = 0;
  string tag = "R8 reset";

  // reference model state
  bit          m_busy = 0, m_done = 0, m_ill = 0;
  int          m_cnt = 0;
  logic [63:0] m_res = '0, m_pend = '0;

  always #10 clk = ~clk;

  divmod_unit dut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .opcode_i(opc),
    .offset_i(off), .dst_i(dst), .src_i(src), .imm_i(imm),
    .busy_o(busy), .done_o(done), .illegal_o(ill), .result_o(res)
  );

  function automatic bit is_legal(input logic [7:0] o, input logic [15:0] f);
    return (o[7:4] == 4'h3 || o[7:4] == 4'h9) &&
           (o[2:0] == 3'h4 || o[2:0] == 3'h7) && (f <= 16'd1);
  endfunction

  function automatic logic [63:0] ref_res(input logic [7:0] o, input logic [15:0] f,
      input logic [63:0] a, input logic [63:0] r, input logic [31:0] im);
    logic [63:0] b;
    bit md, wide;
    b    = o[3] ? r : {{32{im[31]}}, im};
    md   = (o[7:4] == 4'h9);
    wide = (o[2:0] == 3'h7);
    if (wide) begin
      if (f == 0) begin
        longint unsigned ua = a, ub = b;
        if (ub == 0) return md ? ua : 64'd0;
        return md ? ua % ub : ua / ub;
      end else begin
        longint sa = a, sb = b;
        if (sb == 0) return md ? sa : 64'd0;
        if (sa == 64'sh8000000000000000 && sb == -1) return md ? 64'd0 : sa;
        return md ? sa % sb : sa / sb;
      end
    end else begin
      logic [31:0] q;
      if (f == 0) begin
        int unsigned ua = a[31:0], ub = b[31:0];
        if (ub == 0) q = md ? ua : 32'd0;
        else q = md ? ua % ub : ua / ub;
      end else begin
        int sa = a[31:0], sb = b[31:0];
        if (sb == 0) q = md ? sa : 32'd0;
        else if (sa == 32'sh80000000 && sb == -1) q = md ? 32'd0 : sa;
        else q = md ? sa % sb : sa / sb;
      end
      return {32'd0, q};
    end
  endfunction

  // behavioural cycle model
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_busy = 0; m_done = 0; m_ill = 0; m_cnt = 0; m_res = '0;
    end else begin
      m_done = 0; m_ill = 0;
      if (m_busy) begin
        m_cnt--;
        if (m_cnt == 0) begin m_busy = 0; m_done = 1; m_res = m_pend; end
      end else if (start) begin
        if (is_legal(opc, off)) begin
          m_pend = ref_res(opc, off, dst, src, imm);
          m_busy = 1;
          m_cnt  = (opc[2:0] == 3'h7) ? 65 : 33;
        end else m_ill = 1;
      end
    end
  end

  always @(negedge clk) begin
    if (!finished) begin
      vectors++;
      if (busy !== m_busy || done !== m_done || ill !== m_ill || res !== m_res) begin
        fails++;
        $display("FAIL %s: busy %b exp %b, done %b exp %b, illegal %b exp %b, result %h exp %h",
                 tag, busy, m_busy, done, m_done, ill, m_ill, res, m_res);
      end
    end
  end

  task automatic launch(input logic [3:0] op, input bit use_reg, input logic [2:0] cls,
                        input logic [15:0] f, input logic [63:0] a, input logic [63:0] b,
                        input logic [31:0] im);
    opc = {op, use_reg, cls}; off = f; dst = a; src = b; imm = im;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic settle();
    while (m_busy) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic run(input string t, input logic [3:0] op, input bit use_reg,
                     input logic [2:0] cls, input logic [15:0] f,
                     input logic [63:0] a, input logic [63:0] b, input logic [31:0] im);
    tag = t;
    launch(op, use_reg, cls, f, a, b, im);
    settle();
  endtask

  localparam logic [63:0] MIN64 = 64'h8000_0000_0000_0000;

  initial begin
    tag = "R8 reset";
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R2: basic unsigned and signed, both results
    run("R2 udiv64", 4'h3, 1, 3'h7, 0, 64'd1000, 64'd7, 0);
    run("R2 umod64", 4'h9, 1, 3'h7, 0, 64'd1000, 64'd7, 0);
    run("R2 udiv64 large", 4'h3, 1, 3'h7, 0, 64'hFFFF_FFFF_FFFF_FFFF, 64'd3, 0);
    // R1: immediate is sign-extended; register bit selects src
    run("R1 imm neg", 4'h3, 0, 3'h7, 0, 64'hFFFF_FFFF_FFFF_FFF0, 64'd1, 32'hFFFF_FFFF);
    run("R1 imm pos", 4'h9, 0, 3'h7, 0, 64'd100, 64'd1, 32'd16);
    run("R1 imm signed", 4'h3, 0, 3'h7, 1, 64'd100, 64'd0, 32'hFFFF_FFFB);
    // R3: narrow ignores upper bits and zero-extends
    run("R3 narrow udiv", 4'h3, 1, 3'h4, 0, 64'hDEAD_BEEF_0000_0064, 64'h1234_5678_0000_0003, 0);
    run("R3 narrow sdiv", 4'h3, 1, 3'h4, 1, 64'h0000_0001_FFFF_FF9C, 64'd3, 0);
    run("R3 narrow smod", 4'h9, 1, 3'h4, 1, 64'h0000_0000_FFFF_FF9C, 64'd7, 0);
    // R4: zero divisor
    run("R4 udiv by zero", 4'h3, 1, 3'h7, 0, 64'd55, 64'd0, 0);
    run("R4 umod by zero", 4'h9, 1, 3'h7, 0, 64'd55, 64'd0, 0);
    run("R4 smod by zero narrow", 4'h9, 1, 3'h4, 1, 64'hAAAA_AAAA_8000_0001, 64'hFFFF_FFFF_0000_0000, 0);
    run("R4 sdiv by zero imm", 4'h3, 0, 3'h7, 1, 64'hFFFF_FFFF_FFFF_FF00, 64'd9, 32'd0);
    // R5: overflow
    run("R5 sdiv64 min/-1", 4'h3, 1, 3'h7, 1, MIN64, 64'hFFFF_FFFF_FFFF_FFFF, 0);
    run("R5 smod64 min/-1", 4'h9, 1, 3'h7, 1, MIN64, 64'hFFFF_FFFF_FFFF_FFFF, 0);
    run("R5 sdiv32 min/-1", 4'h3, 0, 3'h4, 1, 64'h0000_0000_8000_0000, 0, 32'hFFFF_FFFF);
    run("R5 smod32 min/-1", 4'h9, 0, 3'h4, 1, 64'h0000_0000_8000_0000, 0, 32'hFFFF_FFFF);
    // R6: truncation and remainder sign
    run("R6 -7/2", 4'h3, 1, 3'h7, 1, -64'sd7, 64'd2, 0);
    run("R6 -7%2", 4'h9, 1, 3'h7, 1, -64'sd7, 64'd2, 0);
    run("R6 7/-2", 4'h3, 1, 3'h7, 1, 64'd7, -64'sd2, 0);
    run("R6 7%-2", 4'h9, 1, 3'h7, 1, 64'd7, -64'sd2, 0);
    run("R6 -7%-2", 4'h9, 1, 3'h7, 1, -64'sd7, -64'sd2, 0);
    // R7: rejected encodings
    run("R7 offset 2", 4'h3, 1, 3'h7, 2, 64'd9, 64'd3, 0);
    run("R7 offset ffff", 4'h9, 1, 3'h4, 16'hFFFF, 64'd9, 64'd3, 0);
    run("R7 op e", 4'hE, 1, 3'h7, 0, 64'd9, 64'd3, 0);
    run("R7 op f", 4'hF, 1, 3'h7, 1, 64'd9, 64'd3, 0);
    run("R7 class 3", 4'h3, 1, 3'h3, 0, 64'd9, 64'd3, 0);

    // R10: start while busy is ignored
    tag = "R10 start while busy";
    launch(4'h3, 1, 3'h7, 0, 64'd900, 64'd9, 0);
    repeat (5) @(negedge clk);
    launch(4'h9, 1, 3'h4, 0, 64'd77, 64'd5, 0);
    repeat (20) @(negedge clk);
    launch(4'hE, 1, 3'h7, 7, 64'd1, 64'd1, 0);
    settle();

    // R11: back-to-back, new start in the done cycle
    tag = "R11 back to back";
    launch(4'h3, 1, 3'h4, 1, -64'sd100, 64'd7, 0);
    while (!done) @(negedge clk);
    launch(4'h9, 1, 3'h7, 1, -64'sd100, 64'd7, 0);
    while (!done) @(negedge clk);
    launch(4'h3, 1, 3'h7, 3, 64'd1, 64'd1, 0);  // R7 rejected right after done
    settle();

    // R9: latency and holding across idle gaps under random traffic
    for (int i = 0; i < 200; i++) begin
      logic [63:0] a, b;
      a = {$urandom, $urandom};
      b = {$urandom, $urandom};
      if ($urandom % 3 == 0) b = 64'($urandom % 9);
      if ($urandom % 4 == 0) b = -b;
      tag = "R9 random";
      launch(($urandom % 2) ? 4'h9 : 4'h3, 1'($urandom % 2), ($urandom % 2) ? 3'h7 : 3'h4,
             16'($urandom % 2), a, b, $urandom);
      settle();
      repeat ($urandom % 3) @(negedge clk);
    end

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      fails++;
      $display("FAIL watchdog: run did not end, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end
endmodule